// File: doc/BRIEF.md
# Power Button Shutdown Controller

This block sits beside a processor power sequencer and turns user and platform events into power actions. It watches a debounced power button level, a lid-open level, a warm-reset request and two indications from the sequencer: the system is off, and the system is entering the S3 sleep state. A free-running millisecond tick paces every timer. From these it issues a single-cycle boot request to the sequencer. It also drives the active-low system reset line and the active-low PMIC enable line directly whenever a forced shutdown or a reset pulse is in progress.

A short hold of the button while the system is off boots it. A long hold forces a shutdown at any time, and a new hold restarts that count. A forced shutdown pulls both the reset line and the PMIC enable line low. The enable line is released after a fixed extended period, or earlier if a button boot comes first. When the sequencer enters S3 while the button is still being held, the shutdown happens at once. Opening the lid while off boots with no delay. A warm-reset request yields a reset low pulse of fixed length.

Top module: `pwrkey_shutdown_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, boot_req is 0, sys_rst_l is 1 and pmic_en_l is 1.
- R2: A button press made while sys_off is 1 and held for BOOT_HOLD_MS ticks gives exactly one boot_req pulse, one clock wide, per press. It is registered one cycle after the tick that completes the count.
- R3: A press made while sys_off is 0 gives no boot request. A release before BOOT_HOLD_MS ticks cancels the pending boot.
- R4: A hold of SHUTDOWN_HOLD_MS ticks, with or without a boot, drives sys_rst_l and pmic_en_l to 0 in the same cycle. A release before expiry cancels the shutdown.
- R5: After a forced shutdown, pmic_en_l returns to 1 after PMIC_RELEASE_MS ticks. sys_rst_l stays 0 until the next boot request.
- R6: A boot issued by the button sets pmic_en_l to 1 in the same cycle as boot_req and cancels a pending PMIC release. Every boot request sets sys_rst_l back to 1.
- R7: A rising edge of enter_s3 while the button is held and the shutdown count is running forces the shutdown in the next cycle and stops that count. A rising edge of enter_s3 with the button released has no effect.
- R8: A rising edge of warm_rst_req drives sys_rst_l to 0 for RESET_PULSE_MS ticks. A further request while the pulse is active is ignored and does not stretch it.
- R9: A rising edge of lid_open while sys_off is 1 gives a boot_req in the next cycle. While sys_off is 0 it gives nothing.
- R10: Each timer counts ms_tick pulses after it is armed. A new press restarts the shutdown count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_pressed | input | 1 | Debounced power button level, 1 = held |
| lid_open | input | 1 | Lid level, 1 = open |
| warm_rst_req | input | 1 | Warm-reset request level, acts on its rising edge |
| sys_off | input | 1 | Sequencer reports the system is off |
| enter_s3 | input | 1 | Sequencer reports entry into S3, acts on its rising edge |
| ms_tick | input | 1 | One-cycle pulse once per millisecond |
| boot_req | output | 1 | Single-cycle boot request to the sequencer |
| sys_rst_l | output | 1 | System reset drive, 0 = reset asserted |
| pmic_en_l | output | 1 | PMIC enable drive, 0 = held low |

## Verification
The hardest case to reach from the ports is an S3 entry that lands while the button is held and the shutdown count is still running. The stimulus holds the button for a few ticks with the system on, raises enter_s3 partway through the count, and then releases the button. The release timer must then run from the S3 edge, and no second shutdown may appear at the point where the original count would have expired. Cancellation of a pending PMIC release is reached the same way: a forced shutdown is followed, before the release period ends, by a button boot with the system off. A scoreboard tied to the tick count then rejects any output edge that was not announced.

// File: rtl/pwrkey_pkg.sv
package pwrkey_pkg;
  // Positions of the sampled input levels
  localparam int EVT_N  = 4;
  localparam int E_BTN  = 0;
  localparam int E_LID  = 1;
  localparam int E_WARM = 2;
  localparam int E_S3   = 3;

  // Positions of the millisecond timers
  localparam int TMR_N   = 4;
  localparam int T_BOOT  = 0;
  localparam int T_SHUT  = 1;
  localparam int T_REL   = 2;
  localparam int T_PULSE = 3;
endpackage

// File: rtl/pwrkey_sampler.sv
module pwrkey_sampler #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] prev
);
  // One register per level; the action stage compares against it for edges
  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) prev[g] <= 1'b0;
      else     prev[g] <= lvl[g];
    end
  end
endmodule

// File: rtl/pwrkey_timer.sv
module pwrkey_timer #(
  parameter int unsigned LIMIT = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic arm,
  input  logic cancel,
  output logic active,
  output logic expire
);
  localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      expire <= 1'b0;
      cnt    <= '0;
    end else begin
      expire <= 1'b0;
      if (cancel) begin
        active <= 1'b0;
      end else if (arm) begin
        active <= 1'b1;
        cnt    <= '0;
      end else if (active && tick) begin
        if (cnt == LAST) begin
          active <= 1'b0;
          expire <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pwrkey_action.sv
module pwrkey_action
  import pwrkey_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             sys_off,
  input  logic [EVT_N-1:0] lvl,
  input  logic [EVT_N-1:0] prev,
  input  logic [TMR_N-1:0] tmr_active,
  input  logic [TMR_N-1:0] tmr_expire,
  output logic [TMR_N-1:0] tmr_arm,
  output logic [TMR_N-1:0] tmr_cancel,
  output logic             boot_req,
  output logic             sys_rst_l,
  output logic             pmic_en_l
);
  logic btn_rise, btn_fall, lid_rise, warm_rise, s3_rise;
  logic force_now, boot_btn, boot_now;
  logic rst_hold, rst_hold_next;

  assign btn_rise  = lvl[E_BTN]  & ~prev[E_BTN];
  assign btn_fall  = ~lvl[E_BTN] &  prev[E_BTN];
  assign lid_rise  = lvl[E_LID]  & ~prev[E_LID];
  assign warm_rise = lvl[E_WARM] & ~prev[E_WARM];
  assign s3_rise   = lvl[E_S3]   & ~prev[E_S3];

  // Shutdown on hold expiry, or at once when S3 is entered during a hold
  assign force_now = tmr_expire[T_SHUT] |
                     (s3_rise & lvl[E_BTN] & tmr_active[T_SHUT]);
  assign boot_btn  = tmr_expire[T_BOOT];
  assign boot_now  = boot_btn | (lid_rise & sys_off);

  always_comb begin
    tmr_arm    = '0;
    tmr_cancel = '0;
    tmr_arm[T_BOOT]     = btn_rise & sys_off;
    tmr_cancel[T_BOOT]  = btn_fall & tmr_active[T_BOOT];
    tmr_arm[T_SHUT]     = btn_rise;
    tmr_cancel[T_SHUT]  = btn_fall | force_now;
    tmr_arm[T_REL]      = force_now;
    tmr_cancel[T_REL]   = boot_btn & ~force_now & tmr_active[T_REL];
    // Requests during the pulse, or in its closing cycle, are dropped
    tmr_arm[T_PULSE]    = warm_rise & ~tmr_active[T_PULSE] & ~tmr_expire[T_PULSE];
    tmr_cancel[T_PULSE] = 1'b0;
  end

  always_comb begin
    if (force_now)     rst_hold_next = 1'b1;
    else if (boot_now) rst_hold_next = 1'b0;
    else               rst_hold_next = rst_hold;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      boot_req  <= 1'b0;
      rst_hold  <= 1'b0;
      sys_rst_l <= 1'b1;
      pmic_en_l <= 1'b1;
    end else begin
      boot_req  <= boot_now;
      rst_hold  <= rst_hold_next;
      sys_rst_l <= ~(rst_hold_next | tmr_arm[T_PULSE] | tmr_active[T_PULSE]);
      if (force_now)
        pmic_en_l <= 1'b0;
      else if (boot_btn | tmr_expire[T_REL])
        pmic_en_l <= 1'b1;
    end
  end
endmodule

// File: rtl/pwrkey_shutdown_ctrl.sv
module pwrkey_shutdown_ctrl
  import pwrkey_pkg::*;
#(
  parameter int unsigned BOOT_HOLD_MS     = 10,
  parameter int unsigned SHUTDOWN_HOLD_MS = 8000,
  parameter int unsigned PMIC_RELEASE_MS  = 9000,
  parameter int unsigned RESET_PULSE_MS   = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_pressed,
  input  logic lid_open,
  input  logic warm_rst_req,
  input  logic sys_off,
  input  logic enter_s3,
  input  logic ms_tick,
  output logic boot_req,
  output logic sys_rst_l,
  output logic pmic_en_l
);
  localparam int unsigned LIMS [TMR_N] =
    '{BOOT_HOLD_MS, SHUTDOWN_HOLD_MS, PMIC_RELEASE_MS, RESET_PULSE_MS};

  logic [EVT_N-1:0] lvl, prev;
  logic [TMR_N-1:0] tmr_arm, tmr_cancel, tmr_active, tmr_expire;

  always_comb begin
    lvl         = '0;
    lvl[E_BTN]  = btn_pressed;
    lvl[E_LID]  = lid_open;
    lvl[E_WARM] = warm_rst_req;
    lvl[E_S3]   = enter_s3;
  end

  pwrkey_sampler #(.W(EVT_N)) u_sampler (
    .clk  (clk),
    .rst  (rst),
    .lvl  (lvl),
    .prev (prev)
  );

  for (genvar g = 0; g < TMR_N; g++) begin : g_tmr
    pwrkey_timer #(.LIMIT(LIMS[g])) u_tmr (
      .clk    (clk),
      .rst    (rst),
      .tick   (ms_tick),
      .arm    (tmr_arm[g]),
      .cancel (tmr_cancel[g]),
      .active (tmr_active[g]),
      .expire (tmr_expire[g])
    );
  end

  pwrkey_action u_action (
    .clk        (clk),
    .rst        (rst),
    .sys_off    (sys_off),
    .lvl        (lvl),
    .prev       (prev),
    .tmr_active (tmr_active),
    .tmr_expire (tmr_expire),
    .tmr_arm    (tmr_arm),
    .tmr_cancel (tmr_cancel),
    .boot_req   (boot_req),
    .sys_rst_l  (sys_rst_l),
    .pmic_en_l  (pmic_en_l)
  );
endmodule

// File: rtl/pwrkey_shutdown_ctrl_chk.sv
module pwrkey_shutdown_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic btn_pressed,
  input logic lid_open,
  input logic warm_rst_req,
  input logic sys_off,
  input logic enter_s3,
  input logic boot_req,
  input logic sys_rst_l,
  input logic pmic_en_l,
  input logic shut_active
);
  logic rst_q = 1'b0;

  always @(posedge clk) begin
    if (rst_q) begin
      assert_reset_state_R1: assert (!boot_req && sys_rst_l && pmic_en_l);
    end
    rst_q <= rst;
  end

  assert_boot_single_R2: assert property (@(posedge clk) disable iff (rst)
    boot_req |=> !boot_req);

  assert_force_both_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(pmic_en_l) |-> !sys_rst_l);

  assert_s3_force_R7: assert property (@(posedge clk) disable iff (rst)
    ($rose(enter_s3) && btn_pressed && shut_active) |=> (!pmic_en_l && !sys_rst_l));

  assert_warm_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    ($rose(warm_rst_req) && sys_rst_l) |=> !sys_rst_l);

  assert_lid_boot_R9: assert property (@(posedge clk) disable iff (rst)
    ($rose(lid_open) && sys_off) |=> boot_req);
endmodule

bind pwrkey_shutdown_ctrl pwrkey_shutdown_ctrl_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .btn_pressed  (btn_pressed),
  .lid_open     (lid_open),
  .warm_rst_req (warm_rst_req),
  .sys_off      (sys_off),
  .enter_s3     (enter_s3),
  .boot_req     (boot_req),
  .sys_rst_l    (sys_rst_l),
  .pmic_en_l    (pmic_en_l),
  .shut_active  (tmr_active[1])
);

// File: tb/pwrkey_shutdown_ctrl_bench.sv
module pwrkey_shutdown_ctrl_bench;
  localparam int B  = 3;
  localparam int S  = 12;
  localparam int RL = 15;
  localparam int P  = 5;

  localparam int EV_BOOT = 0, EV_PFALL = 1, EV_PRISE = 2, EV_RFALL = 3, EV_RRISE = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btn = 1'b0, lid = 1'b0, warm = 1'b0, off = 1'b0, s3 = 1'b0;
  logic ms_tick;
  logic boot_req, sys_rst_l, pmic_en_l;

  int cyc = 0;
  int tick_no = 0;
  int n_chk = 0;
  int n_fail = 0;

  typedef struct {
    int    kind;
    int    tick;
    string tag;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (ms_tick) tick_no <= tick_no + 1;
  end
  assign ms_tick = (cyc % 4) == 3;

  pwrkey_shutdown_ctrl #(
    .BOOT_HOLD_MS(B), .SHUTDOWN_HOLD_MS(S),
    .PMIC_RELEASE_MS(RL), .RESET_PULSE_MS(P)
  ) u_pwrkey_shutdown_ctrl (
    .clk(clk), .rst(rst), .btn_pressed(btn), .lid_open(lid),
    .warm_rst_req(warm), .sys_off(off), .enter_s3(s3), .ms_tick(ms_tick),
    .boot_req(boot_req), .sys_rst_l(sys_rst_l), .pmic_en_l(pmic_en_l)
  );

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Driver side: announce an output edge expected at a given tick count
  task automatic expect_ev(int kind, int t, string tag);
    exp_t e;
    e.kind = kind; e.tick = t; e.tag = tag;
    q.push_back(e);
  endtask

  // Tick count seen right after the edge that samples an input set now
  task automatic mark(output int r);
    r = tick_no + (ms_tick ? 1 : 0);
  endtask

  task automatic wait_tick(int t);
    while (tick_no < t) @(negedge clk);
  endtask

  task automatic check_idle(string tag);
    check(q.size() == 0, tag, "expected events still pending", q.size(), 0);
  endtask

  // Monitor: every output edge must match the head of the queue
  logic pm_q = 1'b1, rs_q = 1'b1;

  task automatic see(int kind);
    exp_t e;
    if (q.size() == 0) begin
      check(1'b0, "R3 R4 R7 R9", "spurious output event kind", kind, -1);
    end else begin
      e = q.pop_front();
      check(e.kind == kind, e.tag, "event kind", kind, e.kind);
      check(e.tick == tick_no, e.tag, "event tick", tick_no, e.tick);
    end
  endtask

  always @(negedge clk) begin
    if (rst) begin
      pm_q = 1'b1;
      rs_q = 1'b1;
    end else begin
      if (boot_req) see(EV_BOOT);
      if (pmic_en_l != pm_q) see(pmic_en_l ? EV_PRISE : EV_PFALL);
      if (sys_rst_l != rs_q) see(sys_rst_l ? EV_RRISE : EV_RFALL);
      pm_q = pmic_en_l;
      rs_q = sys_rst_l;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int r, r2;
    repeat (3) @(negedge clk);
    check(boot_req == 1'b0, "R1", "boot_req in reset", boot_req, 0);
    check(sys_rst_l == 1'b1, "R1", "sys_rst_l in reset", sys_rst_l, 1);
    check(pmic_en_l == 1'b1, "R1", "pmic_en_l in reset", pmic_en_l, 1);
    rst = 1'b0;
    @(negedge clk);
    check(boot_req == 1'b0 && sys_rst_l && pmic_en_l, "R1", "outputs after reset",
          {boot_req, sys_rst_l, pmic_en_l}, 3);

    // R2: short hold while off boots once
    off = 1'b1; btn = 1'b1; mark(r);
    expect_ev(EV_BOOT, r + B, "R2");
    wait_tick(r + 6); btn = 1'b0;
    wait_tick(r + 9); check_idle("R2");

    // R3: early release, and press while on
    btn = 1'b1; mark(r);
    wait_tick(r + 2); btn = 1'b0;
    wait_tick(r + 6); off = 1'b0;
    @(negedge clk); btn = 1'b1; mark(r);
    wait_tick(r + 5); btn = 1'b0;
    wait_tick(r + 8); check_idle("R3");

    // R4 and R5: long hold while on
    btn = 1'b1; mark(r);
    expect_ev(EV_PFALL, r + S, "R4");
    expect_ev(EV_RFALL, r + S, "R4");
    expect_ev(EV_PRISE, r + S + RL, "R5");
    wait_tick(r + S + 2); btn = 1'b0;
    wait_tick(r + S + RL + 3);
    check(sys_rst_l == 1'b0, "R5", "sys_rst_l held after PMIC release", sys_rst_l, 0);
    check_idle("R5");

    // R6: button boot brings reset back
    off = 1'b1; @(negedge clk); btn = 1'b1; mark(r);
    expect_ev(EV_BOOT, r + B, "R6");
    expect_ev(EV_RRISE, r + B, "R6");
    wait_tick(r + B + 2); btn = 1'b0;
    wait_tick(r + B + 4); check_idle("R6");

    // R6: boot during a pending PMIC release
    off = 1'b0; @(negedge clk); btn = 1'b1; mark(r);
    expect_ev(EV_PFALL, r + S, "R4");
    expect_ev(EV_RFALL, r + S, "R4");
    wait_tick(r + S + 1); btn = 1'b0;
    off = 1'b1;
    wait_tick(r + S + 3); btn = 1'b1; mark(r2);
    expect_ev(EV_BOOT, r2 + B, "R6");
    expect_ev(EV_PRISE, r2 + B, "R6");
    expect_ev(EV_RRISE, r2 + B, "R6");
    wait_tick(r2 + B + 2); btn = 1'b0;
    wait_tick(r + S + RL + 4);
    check(pmic_en_l == 1'b1, "R6", "pmic_en_l after early boot", pmic_en_l, 1);
    check_idle("R6");

    // R10: a second press restarts the shutdown count
    off = 1'b0; @(negedge clk); btn = 1'b1; mark(r);
    wait_tick(r + 8); btn = 1'b0;
    wait_tick(r + 9); btn = 1'b1; mark(r2);
    expect_ev(EV_PFALL, r2 + S, "R10");
    expect_ev(EV_RFALL, r2 + S, "R10");
    expect_ev(EV_PRISE, r2 + S + RL, "R5");
    wait_tick(r2 + S + 1); btn = 1'b0;
    wait_tick(r2 + S + RL + 2);
    check(sys_rst_l == 1'b0, "R5", "sys_rst_l held until boot", sys_rst_l, 0);
    check_idle("R10");
    off = 1'b1; @(negedge clk); btn = 1'b1; mark(r);
    expect_ev(EV_BOOT, r + B, "R6");
    expect_ev(EV_RRISE, r + B, "R6");
    wait_tick(r + B + 2); btn = 1'b0;
    off = 1'b0;

    // R7: S3 entry during a hold forces shutdown at once
    wait_tick(r + B + 4); btn = 1'b1; mark(r);
    wait_tick(r + 4); s3 = 1'b1; mark(r2);
    expect_ev(EV_PFALL, r2, "R7");
    expect_ev(EV_RFALL, r2, "R7");
    expect_ev(EV_PRISE, r2 + RL, "R7");
    wait_tick(r2 + 2); btn = 1'b0;
    wait_tick(r2 + 3); s3 = 1'b0;
    wait_tick(r2 + RL + 3); check_idle("R7");
    s3 = 1'b1; mark(r);
    wait_tick(r + 3);
    check(pmic_en_l == 1'b1 && sys_rst_l == 1'b0, "R7", "S3 edge without button",
          {pmic_en_l, sys_rst_l}, 2);
    check_idle("R7");
    s3 = 1'b0;

    // R9: lid open while off boots immediately, while on does nothing
    off = 1'b1; @(negedge clk); lid = 1'b1; mark(r);
    expect_ev(EV_BOOT, r, "R9");
    expect_ev(EV_RRISE, r, "R9");
    wait_tick(r + 2); lid = 1'b0;
    off = 1'b0; @(negedge clk); lid = 1'b1; mark(r);
    wait_tick(r + 3); check_idle("R9");
    lid = 1'b0;

    // R8: warm reset pulse, repeat request inside it is ignored
    @(negedge clk); warm = 1'b1; mark(r);
    expect_ev(EV_RFALL, r, "R8");
    expect_ev(EV_RRISE, r + P, "R8");
    wait_tick(r + 1); warm = 1'b0;
    wait_tick(r + 2); warm = 1'b1;
    wait_tick(r + 3); warm = 1'b0;
    wait_tick(r + P + 2); check_idle("R8");
    warm = 1'b1; mark(r);
    expect_ev(EV_RFALL, r, "R8");
    expect_ev(EV_RRISE, r + P, "R8");
    wait_tick(r + 1); warm = 1'b0;
    wait_tick(r + P + 2);
    check(sys_rst_l == 1'b1, "R8", "sys_rst_l after pulse", sys_rst_l, 1);
    check_idle("R8");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule